// File: doc/BRIEF.md
# Single-DWORD Completion Builder

This block forms the completion that a completer-only PCIe endpoint returns for a non-posted request of at most one DWORD. A decoder upstream presents each request already split into its fields (requester ID, tag, traffic class, attribute bits, DWORD address bits, first-DWORD byte enables), a flag saying whether the endpoint supports the request, and the DWORD read from the local bus. The block answers with a three-DWORD completion header and one DWORD of payload, handed over a valid/ready stream to the link-side interface that forwards it to the root complex.

A supported read becomes a completion with data and Successful status. An unsupported request becomes a data-less completion with Completer Abort status and zero length. A read whose byte enables are all clear (a flush) is still answered, with one DWORD of data and a byte count of one. The output stage holds one completion; a new request is taken whenever that stage is empty or being drained in the same cycle.

Top module: `cpl_gen`

## Requirements
- R1: After reset `cpl_valid` is 0 and `req_ready` is 1.
- R2: A supported request with a non-zero byte enable yields header DWORD 0 (`cpl_hdr[95:64]`) with format [31:29]=3'b010, type [28:24]=5'b01010, length [9:0]=1, DWORD 1 (`cpl_hdr[63:32]`) with status [15:13]=3'b000, and `cpl_data` equal to `req_rdata`.
- R3: An unsupported request yields format 3'b000, type 5'b01010, length 0, status 3'b100 (Completer Abort), and `cpl_data` all zero.
- R4: A supported request whose byte enables are 4'b0000 (flush) is answered with format 3'b010, length 1, status 3'b000 and byte count 1.
- R5: DWORD 2 (`cpl_hdr[31:0]`) carries the requester ID in [31:16] and tag in [15:8]; DWORD 0 carries the traffic class in [22:20] and attribute bits in [13:12]; DWORD 1 carries `completer_id` in [31:16].
- R6: The byte count (DWORD 1 [11:0]) equals highest enabled lane minus lowest enabled lane plus one (e.g. 4'b1111 gives 4, 4'b0110 gives 2, 4'b1001 gives 4, 4'b0100 gives 1).
- R7: The lower address (DWORD 2 [6:0]) is `{req_dw_addr, first enabled lane index}`, with lane index 0 when no byte is enabled.
- R8: While `cpl_valid` is 1 and `cpl_ready` is 0, `cpl_valid`, `cpl_hdr` and `cpl_data` stay unchanged and `req_ready` is 0.
- R9: A request accepted at a clock edge (`req_valid` and `req_ready` both 1) appears on the output right after that edge; `req_ready` is 1 whenever the output is empty or `cpl_ready` is 1, so completions can stream one per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| completer_id | input | 16 | Bus/device/function of this endpoint |
| req_valid | input | 1 | Request fields are valid |
| req_ready | output | 1 | Block can take a request this cycle |
| req_rid | input | 16 | Requester ID of the request |
| req_tag | input | 8 | Tag of the request |
| req_tc | input | 3 | Traffic class of the request |
| req_attr | input | 2 | Attribute bits of the request |
| req_dw_addr | input | 5 | Request address bits 6:2 |
| req_be | input | 4 | First-DWORD byte enables |
| req_supported | input | 1 | 1 when the endpoint handles the request |
| req_rdata | input | 32 | DWORD read from the local bus |
| cpl_valid | output | 1 | Completion is presented |
| cpl_ready | input | 1 | Link side takes the completion |
| cpl_hdr | output | 96 | Completion header, DWORD 0 in [95:64] |
| cpl_data | output | 32 | Completion payload DWORD |

## Verification
Every completion is due one edge after acceptance: the bench drives a request on a falling edge, lets one rising edge take it, and reads the header and payload on the next falling edge with `cpl_ready` held low, so the result is compared while it is parked. Draining costs one further edge, after which `cpl_valid` must read 0 on the following falling edge. The stall case keeps `cpl_ready` low for several cycles while offering a competing request and compares the parked completion each cycle; the streaming case holds `cpl_ready` high and expects the second request's header one edge after the first.

// File: rtl/cpl_gen_pkg.sv
package cpl_gen_pkg;
  localparam int HDR_W = 96;
  localparam logic [2:0] FMT_NODATA = 3'b000;
  localparam logic [2:0] FMT_DATA   = 3'b010;
  localparam logic [4:0] TYPE_CPL   = 5'b01010;
  localparam logic [2:0] ST_SC      = 3'b000;
  localparam logic [2:0] ST_CA      = 3'b100;

  typedef struct packed {
    logic [15:0] rid;
    logic [7:0]  tag;
    logic [2:0]  tc;
    logic [1:0]  attr;
    logic [4:0]  dw_addr;
    logic        ok;
  } req_info_t;
endpackage

// File: rtl/cpl_be_span.sv
module cpl_be_span #(
  parameter int BE_W = 4,
  localparam int LANE_W = $clog2(BE_W),
  localparam int BC_W = LANE_W + 1
) (
  input  logic [BE_W-1:0]   be,
  output logic [LANE_W-1:0] first_lane,
  output logic [BC_W-1:0]   byte_cnt
);
  logic [LANE_W-1:0] last_lane;
  logic [BE_W-1:0]   lane_hit;

  genvar g;
  generate
    for (g = 0; g < BE_W; g++) begin : g_lane
      assign lane_hit[g] = be[g];
    end
  endgenerate

  always_comb begin
    first_lane = '0;
    last_lane  = '0;
    for (int i = BE_W - 1; i >= 0; i--)
      if (lane_hit[i]) first_lane = LANE_W'(i);
    for (int i = 0; i < BE_W; i++)
      if (lane_hit[i]) last_lane = LANE_W'(i);
    if (|lane_hit)
      byte_cnt = BC_W'(last_lane - first_lane) + BC_W'(1);
    else
      byte_cnt = BC_W'(1);
  end
endmodule

// File: rtl/cpl_hdr_build.sv
module cpl_hdr_build
  import cpl_gen_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int LANE_W = $clog2(DATA_W / 8),
  localparam int BC_W = LANE_W + 1
) (
  input  req_info_t         info,
  input  logic [15:0]       completer_id,
  input  logic [LANE_W-1:0] first_lane,
  input  logic [BC_W-1:0]   byte_cnt,
  input  logic [DATA_W-1:0] rdata,
  output logic [HDR_W-1:0]  hdr,
  output logic [DATA_W-1:0] data
);
  logic [2:0]  fmt;
  logic [2:0]  status;
  logic [9:0]  len;
  logic [31:0] dw0, dw1, dw2;

  always_comb begin
    fmt    = info.ok ? FMT_DATA : FMT_NODATA;
    status = info.ok ? ST_SC : ST_CA;
    len    = info.ok ? 10'd1 : 10'd0;
    dw0 = {fmt, TYPE_CPL, 1'b0, info.tc, 4'b0000, 1'b0, 1'b0,
           info.attr, 2'b00, len};
    dw1 = {completer_id, status, 1'b0, 12'(byte_cnt)};
    dw2 = {info.rid, info.tag, 1'b0, info.dw_addr, first_lane};
    hdr  = {dw0, dw1, dw2};
    data = info.ok ? rdata : '0;
  end
endmodule

// File: rtl/cpl_out_reg.sv
module cpl_out_reg #(
  parameter int HDR_W = 96,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [HDR_W-1:0]  in_hdr,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [HDR_W-1:0]  out_hdr,
  output logic [DATA_W-1:0] out_data
);
  logic take;
  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst)            out_valid <= 1'b0;
    else if (take)      out_valid <= 1'b1;
    else if (out_ready) out_valid <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (take) begin
      out_hdr  <= in_hdr;
      out_data <= in_data;
    end
  end
endmodule

// File: rtl/cpl_gen.sv
module cpl_gen
  import cpl_gen_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int BE_W = DATA_W / 8,
  localparam int LANE_W = $clog2(BE_W),
  localparam int BC_W = LANE_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [15:0]       completer_id,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [15:0]       req_rid,
  input  logic [7:0]        req_tag,
  input  logic [2:0]        req_tc,
  input  logic [1:0]        req_attr,
  input  logic [4:0]        req_dw_addr,
  input  logic [BE_W-1:0]   req_be,
  input  logic              req_supported,
  input  logic [DATA_W-1:0] req_rdata,
  output logic              cpl_valid,
  input  logic              cpl_ready,
  output logic [HDR_W-1:0]  cpl_hdr,
  output logic [DATA_W-1:0] cpl_data
);
  req_info_t         info;
  logic [LANE_W-1:0] first_lane;
  logic [BC_W-1:0]   byte_cnt;
  logic [HDR_W-1:0]  nxt_hdr;
  logic [DATA_W-1:0] nxt_data;

  assign info = '{rid: req_rid, tag: req_tag, tc: req_tc, attr: req_attr,
                  dw_addr: req_dw_addr, ok: req_supported};

  cpl_be_span #(.BE_W(BE_W)) u_span (
    .be(req_be), .first_lane(first_lane), .byte_cnt(byte_cnt)
  );

  cpl_hdr_build #(.DATA_W(DATA_W)) u_build (
    .info(info), .completer_id(completer_id), .first_lane(first_lane),
    .byte_cnt(byte_cnt), .rdata(req_rdata), .hdr(nxt_hdr), .data(nxt_data)
  );

  cpl_out_reg #(.HDR_W(HDR_W), .DATA_W(DATA_W)) u_out (
    .clk(clk), .rst(rst), .in_valid(req_valid), .in_ready(req_ready),
    .in_hdr(nxt_hdr), .in_data(nxt_data), .out_valid(cpl_valid),
    .out_ready(cpl_ready), .out_hdr(cpl_hdr), .out_data(cpl_data)
  );
endmodule

// File: rtl/cpl_gen_chk.sv
module cpl_gen_chk
  import cpl_gen_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic              cpl_valid,
  input logic              cpl_ready,
  input logic [HDR_W-1:0]  cpl_hdr,
  input logic [DATA_W-1:0] cpl_data
);
  // R8
  hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
    cpl_valid && !cpl_ready |=> cpl_valid && $stable(cpl_hdr) && $stable(cpl_data));
  // R8
  stall_block_chk: assert property (@(posedge clk) disable iff (rst)
    cpl_valid && !cpl_ready |-> !req_ready);
  // R3
  abort_nodata_chk: assert property (@(posedge clk) disable iff (rst)
    cpl_valid && cpl_hdr[47:45] == ST_CA |->
      cpl_hdr[95:93] == FMT_NODATA && cpl_hdr[73:64] == 10'd0 && cpl_data == '0);
  // R2
  cpl_type_chk: assert property (@(posedge clk) disable iff (rst)
    cpl_valid |-> cpl_hdr[92:88] == TYPE_CPL);
  // R2
  data_len_chk: assert property (@(posedge clk) disable iff (rst)
    cpl_valid && cpl_hdr[95:93] == FMT_DATA |->
      cpl_hdr[73:64] == 10'd1 && cpl_hdr[47:45] == ST_SC);
  // R9
  accept_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_ready |=> cpl_valid);
  // R9
  empty_ready_chk: assert property (@(posedge clk) disable iff (rst)
    !cpl_valid |-> req_ready);
endmodule

bind cpl_gen cpl_gen_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .cpl_valid(cpl_valid), .cpl_ready(cpl_ready), .cpl_hdr(cpl_hdr),
  .cpl_data(cpl_data)
);

// File: tb/cpl_gen_bench.sv
module cpl_gen_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic [15:0] completer_id;
  logic        req_valid;
  logic        req_ready;
  logic [15:0] req_rid;
  logic [7:0]  req_tag;
  logic [2:0]  req_tc;
  logic [1:0]  req_attr;
  logic [4:0]  req_dw_addr;
  logic [3:0]  req_be;
  logic        req_supported;
  logic [31:0] req_rdata;
  logic        cpl_valid;
  logic        cpl_ready;
  logic [95:0] cpl_hdr;
  logic [31:0] cpl_data;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  cpl_gen u_cpl_gen (.*);

  task automatic check(string tag, logic [95:0] act, logic [95:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [11:0] exp_bc(logic [3:0] be);
    casez (be)
      4'b1??1: return 12'd4;
      4'b01?1, 4'b1?10: return 12'd3;
      4'b0011, 4'b0110, 4'b1100: return 12'd2;
      default: return 12'd1;
    endcase
  endfunction

  function automatic logic [1:0] exp_lane(logic [3:0] be);
    casez (be)
      4'b???1: return 2'd0;
      4'b??10: return 2'd1;
      4'b?100: return 2'd2;
      4'b1000: return 2'd3;
      default: return 2'd0;
    endcase
  endfunction

  task automatic drive(logic [15:0] rid, logic [7:0] tag, logic [2:0] tc,
                       logic [1:0] attr, logic [4:0] dwa, logic [3:0] be,
                       logic ok, logic [31:0] rd);
    req_rid = rid; req_tag = tag; req_tc = tc; req_attr = attr;
    req_dw_addr = dwa; req_be = be; req_supported = ok; req_rdata = rd;
    req_valid = 1'b1;
  endtask

  task automatic send(logic [15:0] rid, logic [7:0] tag, logic [2:0] tc,
                      logic [1:0] attr, logic [4:0] dwa, logic [3:0] be,
                      logic ok, logic [31:0] rd);
    @(negedge clk);
    drive(rid, tag, tc, attr, dwa, be, ok, rd);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic expect_cpl(string tag, logic [15:0] rid, logic [7:0] t,
                            logic [2:0] tc, logic [1:0] attr, logic [4:0] dwa,
                            logic [3:0] be, logic ok, logic [31:0] rd);
    check({tag, " R9 valid"}, 96'(cpl_valid), 96'd1);
    check({tag, " R2 type"}, 96'(cpl_hdr[92:88]), 96'(5'b01010));
    check({tag, " fmt R2/R3"}, 96'(cpl_hdr[95:93]), ok ? 96'(3'b010) : 96'(3'b000));
    check({tag, " len R2/R3"}, 96'(cpl_hdr[73:64]), ok ? 96'd1 : 96'd0);
    check({tag, " status R2/R3"}, 96'(cpl_hdr[47:45]), ok ? 96'(3'b000) : 96'(3'b100));
    check({tag, " R5 rid"}, 96'(cpl_hdr[31:16]), 96'(rid));
    check({tag, " R5 tag"}, 96'(cpl_hdr[15:8]), 96'(t));
    check({tag, " R5 tc"}, 96'(cpl_hdr[86:84]), 96'(tc));
    check({tag, " R5 attr"}, 96'(cpl_hdr[77:76]), 96'(attr));
    check({tag, " R5 cid"}, 96'(cpl_hdr[63:48]), 96'(completer_id));
    check({tag, " R6 bytecount"}, 96'(cpl_hdr[43:32]), 96'(exp_bc(be)));
    check({tag, " R7 lower addr"}, 96'(cpl_hdr[6:0]), 96'({dwa, exp_lane(be)}));
    if (!ok)
      check({tag, " R3 data zero"}, 96'(cpl_data), 96'd0);
    else if (be != 4'b0000)
      check({tag, " R2 data"}, 96'(cpl_data), 96'(rd));
  endtask

  task automatic drain();
    @(negedge clk);
    cpl_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    cpl_ready = 1'b0;
    check("R9 drained", 96'(cpl_valid), 96'd0);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check("R1 valid after reset", 96'(cpl_valid), 96'd0);
    check("R1 ready after reset", 96'(req_ready), 96'd1);
  endtask

  task automatic t_reads();
    logic [3:0] pats [5] = '{4'b1111, 4'b0110, 4'b1001, 4'b0100, 4'b1100};
    foreach (pats[i]) begin
      send(16'h0100 + 16'(i), 8'h20 + 8'(i), 3'(i), 2'(i), 5'(3 * i + 1),
           pats[i], 1'b1, 32'hCAFE_0000 + 32'(i));
      expect_cpl("read R2", 16'h0100 + 16'(i), 8'h20 + 8'(i), 3'(i), 2'(i),
                 5'(3 * i + 1), pats[i], 1'b1, 32'hCAFE_0000 + 32'(i));
      drain();
    end
  endtask

  task automatic t_unsupported();
    send(16'hBEEF, 8'h7F, 3'd7, 2'd3, 5'h1F, 4'b1110, 1'b0, 32'h1234_5678);
    expect_cpl("abort R3", 16'hBEEF, 8'h7F, 3'd7, 2'd3, 5'h1F, 4'b1110, 1'b0,
               32'h1234_5678);
    drain();
  endtask

  task automatic t_flush();
    send(16'h0042, 8'h05, 3'd2, 2'd1, 5'h0A, 4'b0000, 1'b1, 32'h0);
    expect_cpl("flush R4", 16'h0042, 8'h05, 3'd2, 2'd1, 5'h0A, 4'b0000, 1'b1, 32'h0);
    check("R4 flush bytecount", 96'(cpl_hdr[43:32]), 96'd1);
    drain();
  endtask

  task automatic t_stall();
    logic [95:0] held;
    send(16'h0A0A, 8'h11, 3'd1, 2'd0, 5'h03, 4'b0011, 1'b1, 32'hA5A5_5A5A);
    held = cpl_hdr;
    drive(16'hFFFF, 8'hEE, 3'd6, 2'd2, 5'h15, 4'b1000, 1'b0, 32'hFFFF_FFFF);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check("R8 ready low while stalled", 96'(req_ready), 96'd0);
      check("R8 header held", cpl_hdr, held);
      check("R8 data held", 96'(cpl_data), 96'(32'hA5A5_5A5A));
    end
    req_valid = 1'b0;
    drain();
  endtask

  task automatic t_stream();
    @(negedge clk);
    cpl_ready = 1'b1;
    drive(16'h0001, 8'h01, 3'd0, 2'd0, 5'h01, 4'b1111, 1'b1, 32'h1111_1111);
    @(posedge clk);
    @(negedge clk);
    check("R9 first streamed tag", 96'(cpl_hdr[15:8]), 96'h01);
    check("R9 ready while draining", 96'(req_ready), 96'd1);
    drive(16'h0002, 8'h02, 3'd0, 2'd0, 5'h02, 4'b1111, 1'b1, 32'h2222_2222);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    check("R9 second streamed tag", 96'(cpl_hdr[15:8]), 96'h02);
    check("R9 second streamed data", 96'(cpl_data), 96'(32'h2222_2222));
    @(posedge clk);
    @(negedge clk);
    cpl_ready = 1'b0;
    check("R9 stream empty", 96'(cpl_valid), 96'd0);
  endtask

  initial begin
    completer_id = 16'h0318;
    req_valid = 1'b0; cpl_ready = 1'b0;
    req_rid = '0; req_tag = '0; req_tc = '0; req_attr = '0;
    req_dw_addr = '0; req_be = '0; req_supported = 1'b0; req_rdata = '0;
    t_reset();
    t_reads();
    t_unsupported();
    t_flush();
    t_stall();
    t_stream();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule